// File: doc/BRIEF.md
# Bus Error Capture Unit

This block sits beside a shared on-chip bus and watches every transaction without taking part in it. It keeps a copy of the fields of the most recent address phase: address, master tag, opcode, read and write strobes and privilege level. When a slave answers with the error acknowledge, or when an access gets no response within a programmable number of cycles, the block copies the address, the data and a packed control status word into capture registers. It then locks, so that only the first failure is kept.

Each capture produces a one-cycle service request pulse. An interrupt pulse follows in the same cycle if the interrupt enable input is set. Software reads the three capture registers and pulses a release input to re-arm the unit. If an error arrives in the same cycle as the release, that error is captured.

Top module: `bus_err_capture`

## Requirements
- R1: When `busAck` equals 2'b11 and the unit is unlocked, the capture registers load on that clock edge. `capLocked` reads 1 from the next cycle on.
- R2: `capStatus` is packed from bit 0 upward as follows. Bit 0 is read strobe (active low) and bit 1 is write strobe (active low). Bit 2 is supervisor, with 1 for supervisor and 0 for user. Bits 4:3 are the acknowledge code, bit 5 is ready, bit 6 is abort and bit 7 is the timeout flag. Bits 11:8 are the master tag and bits 12 and up are the opcode.
- R3: Acknowledge codes 2'b00 (no special condition), 2'b01 (split) and 2'b10 (retry) never cause a capture.
- R4: While `capLocked` is 1 and `swRelease` is 0, later errors and timeouts leave `capAddr`, `capData` and `capStatus` unchanged and raise no service request.
- R5: A one-cycle `swRelease` clears `capLocked`. If an error occurs in the same cycle as the release, the new error is captured and the unit stays locked.
- R6: Each capture raises `srqPulse` for exactly one cycle, in the same cycle that the captured values first appear.
- R7: `irq` pulses together with `srqPulse` only when `cfgIrqEn` was 1 in the capture cycle. Otherwise it stays 0.
- R8: With `cfgTimeout` = N > 0, an address phase followed by N cycles without ready and with acknowledge 2'b00 causes a capture at the end of the Nth cycle. The timeout flag (status bit 7) is 1 and the acknowledge, ready and abort fields are 0.
- R9: Ready, or any nonzero acknowledge, in one of those N cycles cancels the timeout. A new address phase before expiry restarts the count for the new access.
- R10: `cfgTimeout` = 0 at the address phase disables timeout detection for that access.
- R11: The captured address, tag, opcode, strobes and supervisor bit come from the most recent address phase. The captured data, acknowledge, ready and abort come from the cycle of the capture.
- R12: After reset, `capLocked`, `srqPulse`, `irq` and all capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddrValid | input | 1 | Address phase of a new access |
| busAddr | input | ADDR_W | Bus address |
| busData | input | DATA_W | Bus data |
| busRdN | input | 1 | Read strobe, active low |
| busWrN | input | 1 | Write strobe, active low |
| busSuper | input | 1 | 1 for supervisor access, 0 for user |
| busTag | input | 4 | Master identification tag |
| busOpc | input | OPC_W | Transaction opcode |
| busAck | input | 2 | Slave acknowledge code |
| busReady | input | 1 | Slave ready |
| busAbort | input | 1 | Abort line |
| cfgTimeout | input | TMO_W | Timeout limit in cycles, 0 disables |
| cfgIrqEn | input | 1 | Interrupt enable |
| swRelease | input | 1 | Release pulse that re-arms capture |
| capAddr | output | ADDR_W | Captured address |
| capData | output | DATA_W | Captured data |
| capStatus | output | 12+OPC_W | Captured control status word |
| capLocked | output | 1 | Capture registers hold an error |
| srqPulse | output | 1 | Service request pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is a timeout that fires on exactly the right cycle. This needs a precise count of idle cycles after an address phase, with nothing on ready or acknowledge in between. The bench sweeps the limit over several values and checks one cycle before expiry and at expiry. It also places a ready in the expiring cycle and a fresh address phase one cycle early, to show that each of these cancels or restarts the count. A release and an error are also driven into the same cycle, to show that the new error wins.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int TAG_W = 4;
  localparam int ACK_W = 2;

  localparam int ST_RDN   = 0;
  localparam int ST_WRN   = 1;
  localparam int ST_SUPER = 2;
  localparam int ST_ACK   = 3;
  localparam int ST_READY = 5;
  localparam int ST_ABORT = 6;
  localparam int ST_TMO   = 7;
  localparam int ST_TAG   = 8;
  localparam int ST_OPC   = ST_TAG + TAG_W;

  typedef enum logic [ACK_W-1:0] {
    ACK_NONE  = 2'b00,
    ACK_SPLIT = 2'b01,
    ACK_RETRY = 2'b10,
    ACK_ERROR = 2'b11
  } ackCodeT;

  typedef struct packed {
    logic trackPhase;
    logic capture;
    logic tmoFlag;
  } dpStrobeT;
endpackage

// File: rtl/bec_timeout.sv
module bec_timeout #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [TMO_W-1:0] limit,
  input  logic             response,
  output logic             expire
);
  localparam logic [TMO_W-1:0] LastTick = TMO_W'(1);

  logic [TMO_W-1:0] count;
  logic             pending;

  assign expire = pending && !response && (count == LastTick);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      pending <= 1'b0;
    end else if (load) begin
      count   <= limit;
      pending <= (limit != '0);
    end else if (pending) begin
      if (response || expire) begin
        pending <= 1'b0;
      end else begin
        count <= count - LastTick;
      end
    end
  end
endmodule

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busAddrValid,
  input  logic [ACK_W-1:0] busAck,
  input  logic             busReady,
  input  logic [TMO_W-1:0] cfgTimeout,
  input  logic             cfgIrqEn,
  input  logic             swRelease,
  output dpStrobeT         strobe,
  output logic             capLocked,
  output logic             srqPulse,
  output logic             irq
);
  logic response;
  logic tmoHit;
  logic errHit;
  logic armed;
  logic captureNow;

  assign response   = busReady || (busAck != ACK_NONE);
  assign errHit     = (busAck == ACK_ERROR);
  assign armed      = !capLocked || swRelease;
  assign captureNow = armed && (errHit || tmoHit);

  bec_timeout #(.TMO_W(TMO_W)) u_timeout (
    .clk     (clk),
    .rstN    (rstN),
    .load    (busAddrValid),
    .limit   (cfgTimeout),
    .response(response),
    .expire  (tmoHit)
  );

  always_comb begin
    strobe.trackPhase = busAddrValid;
    strobe.capture    = captureNow;
    strobe.tmoFlag    = tmoHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capLocked <= 1'b0;
      srqPulse  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (captureNow) begin
        capLocked <= 1'b1;
      end else if (swRelease) begin
        capLocked <= 1'b0;
      end
      srqPulse <= captureNow;
      irq      <= captureNow && cfgIrqEn;
    end
  end
endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OPC_W  = 4,
  parameter int STAT_W = ST_OPC + OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic              busSuper,
  input  logic [TAG_W-1:0]  busTag,
  input  logic [OPC_W-1:0]  busOpc,
  input  logic [ACK_W-1:0]  busAck,
  input  logic              busReady,
  input  logic              busAbort,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic [STAT_W-1:0] capStatus
);
  logic [ADDR_W-1:0] phAddr;
  logic [TAG_W-1:0]  phTag;
  logic [OPC_W-1:0]  phOpc;
  logic              phRdN;
  logic              phWrN;
  logic              phSuper;
  logic [STAT_W-1:0] statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phAddr  <= '0;
      phTag   <= '0;
      phOpc   <= '0;
      phRdN   <= 1'b0;
      phWrN   <= 1'b0;
      phSuper <= 1'b0;
    end else if (strobe.trackPhase) begin
      phAddr  <= busAddr;
      phTag   <= busTag;
      phOpc   <= busOpc;
      phRdN   <= busRdN;
      phWrN   <= busWrN;
      phSuper <= busSuper;
    end
  end

  always_comb begin
    statusNext                    = '0;
    statusNext[ST_RDN]            = phRdN;
    statusNext[ST_WRN]            = phWrN;
    statusNext[ST_SUPER]          = phSuper;
    statusNext[ST_ACK +: ACK_W]   = busAck;
    statusNext[ST_READY]          = busReady;
    statusNext[ST_ABORT]          = busAbort;
    statusNext[ST_TMO]            = strobe.tmoFlag;
    statusNext[ST_TAG +: TAG_W]   = phTag;
    statusNext[ST_OPC +: OPC_W]   = phOpc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capAddr   <= '0;
      capData   <= '0;
      capStatus <= '0;
    end else if (strobe.capture) begin
      capAddr   <= phAddr;
      capData   <= busData;
      capStatus <= statusNext;
    end
  end
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OPC_W  = 4,
  parameter int TMO_W  = 8,
  localparam int STAT_W = ST_OPC + OPC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddrValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busRdN,
  input  logic              busWrN,
  input  logic              busSuper,
  input  logic [3:0]        busTag,
  input  logic [OPC_W-1:0]  busOpc,
  input  logic [1:0]        busAck,
  input  logic              busReady,
  input  logic              busAbort,
  input  logic [TMO_W-1:0]  cfgTimeout,
  input  logic              cfgIrqEn,
  input  logic              swRelease,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic [STAT_W-1:0] capStatus,
  output logic              capLocked,
  output logic              srqPulse,
  output logic              irq
);
  dpStrobeT strobe;

  bec_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busAddrValid(busAddrValid),
    .busAck      (busAck),
    .busReady    (busReady),
    .cfgTimeout  (cfgTimeout),
    .cfgIrqEn    (cfgIrqEn),
    .swRelease   (swRelease),
    .strobe      (strobe),
    .capLocked   (capLocked),
    .srqPulse    (srqPulse),
    .irq         (irq)
  );

  bec_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OPC_W (OPC_W),
    .STAT_W(STAT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .busData  (busData),
    .busRdN   (busRdN),
    .busWrN   (busWrN),
    .busSuper (busSuper),
    .busTag   (busTag),
    .busOpc   (busOpc),
    .busAck   (busAck),
    .busReady (busReady),
    .busAbort (busAbort),
    .capAddr  (capAddr),
    .capData  (capData),
    .capStatus(capStatus)
  );
endmodule

// File: rtl/bus_err_capture_chk.sv
module bus_err_capture_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAck,
  input logic              cfgIrqEn,
  input logic              swRelease,
  input logic [ADDR_W-1:0] capAddr,
  input logic [DATA_W-1:0] capData,
  input logic [STAT_W-1:0] capStatus,
  input logic              capLocked,
  input logic              srqPulse,
  input logic              irq
);
  p_error_captures_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busAck == 2'b11 && (!capLocked || swRelease)) |=>
      (capLocked && srqPulse && capStatus[4:3] == 2'b11));

  p_retry_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!capLocked && !swRelease && busAck == 2'b10) |=> !capLocked);

  p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (capLocked && !swRelease) |=>
      ($stable(capAddr) && $stable(capData) && $stable(capStatus) && !srqPulse));

  p_release_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swRelease && busAck != 2'b11 && !srqPulse && capLocked) |=> (!capLocked || srqPulse));

  p_srq_on_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capLocked) |-> srqPulse);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (srqPulse && $past(cfgIrqEn)));
endmodule

bind bus_err_capture bus_err_capture_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .STAT_W(STAT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAck   (busAck),
  .cfgIrqEn (cfgIrqEn),
  .swRelease(swRelease),
  .capAddr  (capAddr),
  .capData  (capData),
  .capStatus(capStatus),
  .capLocked(capLocked),
  .srqPulse (srqPulse),
  .irq      (irq)
);

// File: tb/bus_err_capture_bench.sv
module bus_err_capture_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OPC_W  = 4;
  localparam int TMO_W  = 8;
  localparam int STAT_W = 12 + OPC_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddrValid = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busData = '0;
  logic busRdN = 1'b1, busWrN = 1'b1, busSuper = 1'b0;
  logic [3:0] busTag = '0;
  logic [OPC_W-1:0] busOpc = '0;
  logic [1:0] busAck = 2'b00;
  logic busReady = 1'b0, busAbort = 1'b0;
  logic [TMO_W-1:0] cfgTimeout = '0;
  logic cfgIrqEn = 1'b0;
  logic swRelease = 1'b0;
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic [STAT_W-1:0] capStatus;
  logic capLocked, srqPulse, irq;

  int checks = 0;
  int fails = 0;

  logic [ADDR_W-1:0] eAddr;
  logic [3:0] eTag;
  logic [OPC_W-1:0] eOpc;
  logic eRdN, eWrN, eSup;

  always #10 clk = ~clk;

  bus_err_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .TMO_W(TMO_W)) u_bus_err_capture (
    .clk(clk), .rstN(rstN), .busAddrValid(busAddrValid), .busAddr(busAddr), .busData(busData),
    .busRdN(busRdN), .busWrN(busWrN), .busSuper(busSuper), .busTag(busTag), .busOpc(busOpc),
    .busAck(busAck), .busReady(busReady), .busAbort(busAbort), .cfgTimeout(cfgTimeout),
    .cfgIrqEn(cfgIrqEn), .swRelease(swRelease), .capAddr(capAddr), .capData(capData),
    .capStatus(capStatus), .capLocked(capLocked), .srqPulse(srqPulse), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [STAT_W-1:0] status(input logic rdN, input logic wrN, input logic sup,
      input logic [1:0] ack, input logic rdy, input logic abt, input logic tmo,
      input logic [3:0] tag, input logic [OPC_W-1:0] opc);
    return STAT_W'(rdN) | (STAT_W'(wrN) << 1) | (STAT_W'(sup) << 2) | (STAT_W'(ack) << 3) |
           (STAT_W'(rdy) << 5) | (STAT_W'(abt) << 6) | (STAT_W'(tmo) << 7) |
           (STAT_W'(tag) << 8) | (STAT_W'(opc) << 12);
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic addrPhase(input logic [ADDR_W-1:0] a, input logic [3:0] t, input logic [OPC_W-1:0] o,
                           input logic rd, input logic wr, input logic s);
    busAddrValid = 1'b1; busAddr = a; busTag = t; busOpc = o; busRdN = rd; busWrN = wr; busSuper = s;
    eAddr = a; eTag = t; eOpc = o; eRdN = rd; eWrN = wr; eSup = s;
    @(negedge clk);
    busAddrValid = 1'b0; busAddr = ~a; busTag = ~t; busOpc = ~o; busSuper = ~s;
  endtask

  task automatic dataPhase(input logic [DATA_W-1:0] d, input logic [1:0] ack, input logic rdy,
                           input logic abt, input logic rel);
    busData = d; busAck = ack; busReady = rdy; busAbort = abt; swRelease = rel;
    @(negedge clk);
    busAck = 2'b00; busReady = 1'b0; busAbort = 1'b0; swRelease = 1'b0; busData = ~d;
  endtask

  task automatic release_lock();
    swRelease = 1'b1;
    @(negedge clk);
    swRelease = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R12 reset state
    check("R12", "locked", 64'(capLocked), 0);
    check("R12", "srq", 64'(srqPulse), 0);
    check("R12", "irq", 64'(irq), 0);
    check("R12", "addr", 64'(capAddr), 0);
    check("R12", "data", 64'(capData), 0);
    check("R12", "status", 64'(capStatus), 0);

    // R3: non-error acknowledge codes do not capture
    for (int a = 0; a < 3; a++) begin
      addrPhase(32'h100 + 32'(a), 4'(a), 4'(a), 1'b0, 1'b1, 1'b0);
      dataPhase(32'hA0 + 32'(a), 2'(a), a == 0, 1'b0, 1'b0);
      check("R3", "locked after non-error ack", 64'(capLocked), 0);
      check("R3", "srq after non-error ack", 64'(srqPulse), 0);
    end

    // R1 R2 R11: error capture over every tag
    for (int t = 0; t < 16; t++) begin
      logic [DATA_W-1:0] d;
      d = 32'hDEAD0000 + 32'(t * 17);
      addrPhase(32'h4000_0040 + 32'(t << 12), 4'(t), 4'(15 - t), t[0], ~t[0], t[1]);
      dataPhase(d, 2'b11, t[2], t[3], 1'b0);
      check("R1", "locked", 64'(capLocked), 1);
      check("R11", "addr", 64'(capAddr), 64'(eAddr));
      check("R11", "data", 64'(capData), 64'(d));
      check("R2", "status", 64'(capStatus),
            64'(status(eRdN, eWrN, eSup, 2'b11, t[2], t[3], 1'b0, eTag, eOpc)));
      check("R6", "srq with capture", 64'(srqPulse), 1);
      idle(1);
      check("R6", "srq one cycle", 64'(srqPulse), 0);
      release_lock();
      check("R5", "release clears lock", 64'(capLocked), 0);
    end

    // R4: first error kept
    addrPhase(32'h1111_0000, 4'h3, 4'h5, 1'b0, 1'b1, 1'b1);
    dataPhase(32'h0000_AAAA, 2'b11, 1'b0, 1'b0, 1'b0);
    addrPhase(32'h2222_0000, 4'h9, 4'h6, 1'b1, 1'b0, 1'b0);
    dataPhase(32'h0000_BBBB, 2'b11, 1'b0, 1'b1, 1'b0);
    check("R4", "addr kept", 64'(capAddr), 64'h1111_0000);
    check("R4", "data kept", 64'(capData), 64'h0000_AAAA);
    check("R4", "status kept", 64'(capStatus),
          64'(status(1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 4'h3, 4'h5)));
    check("R4", "no srq while locked", 64'(srqPulse), 0);

    // R5: release and error in the same cycle
    addrPhase(32'h3333_0000, 4'hC, 4'h2, 1'b1, 1'b0, 1'b0);
    dataPhase(32'h0000_CCCC, 2'b11, 1'b0, 1'b0, 1'b1);
    check("R5", "locked after release+error", 64'(capLocked), 1);
    check("R5", "new addr", 64'(capAddr), 64'h3333_0000);
    check("R5", "srq", 64'(srqPulse), 1);
    release_lock();

    // R7 interrupt gating
    cfgIrqEn = 1'b1;
    addrPhase(32'h50, 4'h1, 4'h1, 1'b0, 1'b1, 1'b0);
    dataPhase(32'h51, 2'b11, 1'b0, 1'b0, 1'b0);
    check("R7", "irq enabled", 64'(irq), 1);
    release_lock();
    check("R7", "irq drops", 64'(irq), 0);
    cfgIrqEn = 1'b0;
    addrPhase(32'h60, 4'h2, 4'h2, 1'b0, 1'b1, 1'b0);
    dataPhase(32'h61, 2'b11, 1'b0, 1'b0, 1'b0);
    check("R7", "irq disabled", 64'(irq), 0);
    check("R7", "srq still raised", 64'(srqPulse), 1);
    release_lock();

    // R8 timeout sweep
    for (int n = 1; n <= 5; n++) begin
      cfgTimeout = 8'(n);
      busData = 32'h7700 + 32'(n);
      addrPhase(32'h8000_0000 + 32'(n), 4'(n + 5), 4'(n), 1'b1, 1'b0, n[0]);
      busData = 32'h7700 + 32'(n);
      if (n > 1) begin
        idle(n - 1);
        check("R8", "not yet expired", 64'(capLocked), 0);
        idle(1);
      end else begin
        idle(1);
      end
      check("R8", "expired", 64'(capLocked), 1);
      check("R8", "srq", 64'(srqPulse), 1);
      check("R8", "addr", 64'(capAddr), 64'(eAddr));
      check("R8", "data", 64'(capData), 64'h7700 + 64'(n));
      check("R8", "status", 64'(capStatus),
            64'(status(eRdN, eWrN, eSup, 2'b00, 1'b0, 1'b0, 1'b1, eTag, eOpc)));
      release_lock();
    end

    // R9: ready in the expiring cycle cancels
    cfgTimeout = 8'd4;
    addrPhase(32'h9000, 4'h4, 4'h4, 1'b0, 1'b1, 1'b0);
    idle(3);
    dataPhase(32'h9001, 2'b00, 1'b1, 1'b0, 1'b0);
    idle(6);
    check("R9", "ready cancels", 64'(capLocked), 0);
    // R9: new address phase restarts count
    addrPhase(32'hA000, 4'h5, 4'h5, 1'b0, 1'b1, 1'b0);
    idle(2);
    addrPhase(32'hB000, 4'h6, 4'h6, 1'b1, 1'b0, 1'b1);
    idle(3);
    check("R9", "restart not expired", 64'(capLocked), 0);
    idle(1);
    check("R9", "restart expired", 64'(capLocked), 1);
    check("R9", "restart addr", 64'(capAddr), 64'hB000);
    release_lock();

    // R10: zero disables timeout
    cfgTimeout = 8'd0;
    addrPhase(32'hC000, 4'h7, 4'h7, 1'b0, 1'b1, 1'b0);
    idle(20);
    check("R10", "no timeout when zero", 64'(capLocked), 0);
    check("R10", "no srq when zero", 64'(srqPulse), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule